// File: doc/BRIEF.md
# Parallel port host register window

This block puts a printer-style parallel port behind a byte-wide host register window of eight registers. The host reaches the port with single-cycle read and write strobes. The block holds the output data byte and a six-bit control register, drives the eight data lines and four control lines, and samples the five peripheral status lines, the data pins and a wait input through a synchronizer. It also keeps a sticky timeout flag and an interrupt flag.

Accesses to the enhanced-mode address register or to any of the four enhanced-mode data registers start a short handshake toward the peripheral. An address strobe or a data strobe goes low for a fixed number of clocks. The handshake then waits a bounded time for the wait input and flags a timeout when the wait input never answers. Read data is combinational from the current state. Read side effects, such as clearing flags, take place at the clock edge that samples the read strobe.

Top module: `pport_regwin`

## Requirements
- R1: The register index is taken from address bits [4:2], so register n sits at byte address 4*n and address bits [1:0] have no effect. Indices are 0 data, 1 status, 2 control, 3 enhanced address, and 4 to 7 enhanced data.
- R2: With the direction bit (control bit 5) at 0, `pd_oe` is 1, `pd_out` carries the last byte written to index 0, and a read of index 0 returns that byte unchanged.
- R3: With the direction bit at 1 and no enhanced write in progress, `pd_oe` is 0. A read of index 0 then returns `pd_in` as sampled through a two-stage synchronizer, and the stored data byte is kept for the return to output mode.
- R4: The control register stores write bits [5:0]: bit 0 drives `lp_strobe`, bit 1 drives `lp_autofeed`, bit 2 drives `lp_init_n`, bit 3 drives `lp_select_in`, bit 4 is interrupt enable and bit 5 is direction. Read bits [7:6] are 0.
- R5: A status read returns the synchronized pins with busy_n in bit 7, ack_n in bit 6, paper-end in bit 5, select in bit 4 and err_n in bit 3. Bits 2 and 1 read as 0, and the timeout flag is in bit 0.
- R6: Writes to index 1 change no register, no output and no flag.
- R7: A read or write of index 3 drives `epp_astb_n` low for exactly 2 clocks, and a read or write of index 4 to 7 does the same on `epp_dstb_n`. From the access edge until the handshake ends, a write holds `epp_write_n` low and drives the written byte on `pd_out` with `pd_oe` high.
- R8: If the synchronized `epp_wait` is not seen high within 16 clocks of the access edge, the handshake ends and the timeout flag is set. A status read clears the flag, and a new timeout in the same cycle takes priority.
- R9: A falling edge of synchronized ack_n while interrupt enable is 1 sets the interrupt flag. A status read clears it. `irq` is the flag ANDed with interrupt enable, and falling edges seen while the enable is 0 are lost.
- R10: A read of index 3 to 7 returns the synchronized `pd_in`. An access to index 3 to 7 that arrives while a handshake is still running starts nothing.
- R11: After reset the data byte, control register, timeout flag and interrupt flag are 0, so `pd_oe` is 1, `pd_out` is 0, `lp_init_n` is 0, both handshake strobes and `epp_write_n` are 1, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Host byte address, register index in bits [4:2] |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational |
| pd_out | output | 8 | Parallel data output value |
| pd_oe | output | 1 | Parallel data output enable |
| pd_in | input | 8 | Parallel data pins as seen by the block |
| lp_strobe | output | 1 | Control line from control bit 0 |
| lp_autofeed | output | 1 | Control line from control bit 1 |
| lp_init_n | output | 1 | Control line from control bit 2 |
| lp_select_in | output | 1 | Control line from control bit 3 |
| pin_err_n | input | 1 | Peripheral error, active low |
| pin_select | input | 1 | Peripheral selected |
| pin_paper_end | input | 1 | Peripheral out of paper |
| pin_ack_n | input | 1 | Peripheral acknowledge, active low |
| pin_busy_n | input | 1 | Peripheral busy line, as read in status bit 7 |
| epp_wait | input | 1 | Peripheral handshake response |
| epp_astb_n | output | 1 | Enhanced address strobe, active low |
| epp_dstb_n | output | 1 | Enhanced data strobe, active low |
| epp_write_n | output | 1 | Low while an enhanced write handshake runs |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume that the host never raises `bus_rd` and `bus_wr` in the same cycle. They also treat a status read as the only way to clear the flags, so a flag may drop only at an edge where a status read was sampled and no new event arrived. The stimulus drives each strobe for a single cycle, changes pins only at the falling clock edge, and holds the status and ack pins steady for several clocks, so every edge passes cleanly through the two synchronizer stages. The wait input is held either high or low for a whole handshake, which separates the fast-response path from the full timeout path.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int DW    = 8;
  localparam int OFF_W = 3;
  localparam int CTL_W = 6;

  typedef enum logic [OFF_W-1:0] {
    IDX_DATA  = 3'd0,
    IDX_STAT  = 3'd1,
    IDX_CTRL  = 3'd2,
    IDX_EADR  = 3'd3,
    IDX_EDAT0 = 3'd4,
    IDX_EDAT1 = 3'd5,
    IDX_EDAT2 = 3'd6,
    IDX_EDAT3 = 3'd7
  } reg_idx_e;

  localparam int C_STROBE = 0;
  localparam int C_AFD    = 1;
  localparam int C_INIT   = 2;
  localparam int C_SELIN  = 3;
  localparam int C_IEN    = 4;
  localparam int C_DIR    = 5;

  localparam int P_ERR  = 0;
  localparam int P_SEL  = 1;
  localparam int P_PE   = 2;
  localparam int P_ACK  = 3;
  localparam int P_BUSY = 4;
  localparam int P_PD   = 5;
  localparam int P_WAIT = P_PD + DW;
  localparam int PIN_W  = P_WAIT + 1;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pport_epp.sv
module pport_epp #(
  parameter int DW      = 8,
  parameter int STB_CYC = 2,
  parameter int TMO_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_addr,
  input  logic          start_wr,
  input  logic [DW-1:0] start_byte,
  input  logic          wait_s,
  output logic          busy,
  output logic          astb_n,
  output logic          dstb_n,
  output logic          wr_active,
  output logic [DW-1:0] byte_q,
  output logic          tmo_set
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STB_CYC - 1);
  localparam logic [CNT_W-1:0] STB_END  = CNT_W'(STB_CYC);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cyc_q, cyc_d;
  logic             seen_q, seen_d;
  logic             isaddr_q, isaddr_d;
  logic             iswr_q, iswr_d;
  logic [DW-1:0]    byte_d;
  logic             resp;
  logic             byte_en;

  assign resp    = seen_q | wait_s;
  assign byte_en = start;

  always_comb begin
    busy_d   = busy_q;
    cyc_d    = cyc_q;
    seen_d   = seen_q;
    isaddr_d = isaddr_q;
    iswr_d   = iswr_q;
    byte_d   = byte_q;
    tmo_set  = 1'b0;
    if (start) begin
      busy_d   = 1'b1;
      cyc_d    = '0;
      seen_d   = 1'b0;
      isaddr_d = start_addr;
      iswr_d   = start_wr;
      byte_d   = start_byte;
    end else if (busy_q) begin
      if ((cyc_q >= STB_LAST) && resp) begin
        busy_d = 1'b0;
      end else if (cyc_q == TMO_LAST) begin
        busy_d  = 1'b0;
        tmo_set = 1'b1;
      end else begin
        cyc_d  = cyc_q + 1'b1;
        seen_d = resp;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cyc_q    <= '0;
      seen_q   <= 1'b0;
      isaddr_q <= 1'b0;
      iswr_q   <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      cyc_q    <= cyc_d;
      seen_q   <= seen_d;
      isaddr_q <= isaddr_d;
      iswr_q   <= iswr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (byte_en) byte_q <= byte_d;
  end

  logic strobe_on;
  assign strobe_on = busy_q && (cyc_q < STB_END);
  assign busy      = busy_q;
  assign astb_n    = ~(strobe_on & isaddr_q);
  assign dstb_n    = ~(strobe_on & ~isaddr_q);
  assign wr_active = busy_q & iswr_q;
endmodule

// File: rtl/pport_flags.sv
module pport_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s,
  input  logic ien,
  input  logic stat_rd,
  input  logic tmo_set,
  output logic tmo,
  output logic irq_flag,
  output logic ack_fall
);
  logic ack_d_q;
  logic tmo_q, tmo_d;
  logic irq_q, irq_d;

  assign ack_fall = ack_d_q & ~ack_s;

  always_comb begin
    tmo_d = tmo_q;
    if (tmo_set)      tmo_d = 1'b1;
    else if (stat_rd) tmo_d = 1'b0;

    irq_d = irq_q;
    if (ack_fall && ien) irq_d = 1'b1;
    else if (stat_rd)    irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d_q <= 1'b0;
      tmo_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      ack_d_q <= ack_s;
      tmo_q   <= tmo_d;
      irq_q   <= irq_d;
    end
  end

  assign tmo      = tmo_q;
  assign irq_flag = irq_q;
endmodule

// File: rtl/pport_regwin.sv
module pport_regwin
  import pport_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int STB_CYC     = 2,
  parameter int TMO_CYC     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [DW-1:0]     pd_out,
  output logic              pd_oe,
  input  logic [DW-1:0]     pd_in,
  output logic              lp_strobe,
  output logic              lp_autofeed,
  output logic              lp_init_n,
  output logic              lp_select_in,
  input  logic              pin_err_n,
  input  logic              pin_select,
  input  logic              pin_paper_end,
  input  logic              pin_ack_n,
  input  logic              pin_busy_n,
  input  logic              epp_wait,
  output logic              epp_astb_n,
  output logic              epp_dstb_n,
  output logic              epp_write_n,
  output logic              irq
);
  localparam int OFF_LSB = 2;

  // register index decode (byte address bits [1:0] dropped)
  reg_idx_e idx;
  logic     unused_addr;
  assign idx         = reg_idx_e'(bus_addr[OFF_LSB +: OFF_W]);
  assign unused_addr = ^bus_addr;

  logic data_en, ctrl_en, stat_rd, epp_sel, epp_start;
  assign data_en = bus_wr && (idx == IDX_DATA);
  assign ctrl_en = bus_wr && (idx == IDX_CTRL);
  assign stat_rd = bus_rd && (idx == IDX_STAT);
  assign epp_sel = (idx >= IDX_EADR);

  // data and control registers
  logic [DW-1:0]    data_q, data_d;
  logic [CTL_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    data_d = data_q;
    ctrl_d = ctrl_q;
    if (data_en) data_d = bus_wdata;
    if (ctrl_en) ctrl_d = bus_wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // input synchronizer
  logic [PIN_W-1:0] pin_raw, pin_s;
  assign pin_raw = {epp_wait, pd_in, pin_busy_n, pin_ack_n,
                    pin_paper_end, pin_select, pin_err_n};

  pport_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (pin_s)
  );

  logic [DW-1:0] pd_s;
  assign pd_s = pin_s[P_PD +: DW];

  // enhanced-mode handshake
  logic          epp_busy, epp_wr_active, tmo_set;
  logic [DW-1:0] epp_byte;
  assign epp_start = (bus_wr | bus_rd) & epp_sel & ~epp_busy;

  pport_epp #(.DW(DW), .STB_CYC(STB_CYC), .TMO_CYC(TMO_CYC)) u_epp (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (epp_start),
    .start_addr (idx == IDX_EADR),
    .start_wr   (bus_wr),
    .start_byte (bus_wdata),
    .wait_s     (pin_s[P_WAIT]),
    .busy       (epp_busy),
    .astb_n     (epp_astb_n),
    .dstb_n     (epp_dstb_n),
    .wr_active  (epp_wr_active),
    .byte_q     (epp_byte),
    .tmo_set    (tmo_set)
  );

  // sticky flags
  logic tmo_flag, irq_flag, ack_fall;

  pport_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_s    (pin_s[P_ACK]),
    .ien      (ctrl_q[C_IEN]),
    .stat_rd  (stat_rd),
    .tmo_set  (tmo_set),
    .tmo      (tmo_flag),
    .irq_flag (irq_flag),
    .ack_fall (ack_fall)
  );

  // read mux
  logic [DW-1:0] stat_val;
  assign stat_val = {pin_s[P_BUSY], pin_s[P_ACK], pin_s[P_PE], pin_s[P_SEL],
                     pin_s[P_ERR], 2'b00, tmo_flag};

  always_comb begin
    unique case (idx)
      IDX_DATA: bus_rdata = ctrl_q[C_DIR] ? pd_s : data_q;
      IDX_STAT: bus_rdata = stat_val;
      IDX_CTRL: bus_rdata = {{(DW-CTL_W){1'b0}}, ctrl_q};
      default:  bus_rdata = pd_s;
    endcase
  end

  // pin outputs
  assign pd_oe        = epp_wr_active | ~ctrl_q[C_DIR];
  assign pd_out       = epp_wr_active ? epp_byte : data_q;
  assign epp_write_n  = ~epp_wr_active;
  assign lp_strobe    = ctrl_q[C_STROBE];
  assign lp_autofeed  = ctrl_q[C_AFD];
  assign lp_init_n    = ctrl_q[C_INIT];
  assign lp_select_in = ctrl_q[C_SELIN];
  assign irq          = irq_flag & ctrl_q[C_IEN];
endmodule

// File: rtl/pport_regwin_chk.sv
module pport_regwin_chk #(
  parameter int TMO_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] idx,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       pd_oe,
  input logic       epp_astb_n,
  input logic       epp_dstb_n,
  input logic       epp_write_n,
  input logic       irq,
  input logic       ctl_dir,
  input logic       ctl_ien,
  input logic       epp_busy,
  input logic       tmo_flag,
  input logic       tmo_set,
  input logic       ack_fall
);
  localparam int RUN_W = $clog2(TMO_CYC + 1);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (epp_busy) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!epp_astb_n && !epp_dstb_n));

  assert_astb_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(epp_astb_n) |=> !epp_astb_n ##1 epp_astb_n);

  assert_dstb_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(epp_dstb_n) |=> !epp_dstb_n ##1 epp_dstb_n);

  assert_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    epp_busy |-> (run_q < RUN_W'(TMO_CYC)));

  assert_tmo_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == 3'd1 && !tmo_set) |=> !tmo_flag);

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == 3'd1 && !ack_fall) |=> !irq);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl_ien);

  assert_dir_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_dir && epp_write_n) |-> !pd_oe);

  assert_stat_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == 3'd1) |-> (bus_rdata[2:1] == 2'b00));

  assert_ctrl_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == 3'd2) |-> (bus_rdata[7:6] == 2'b00));
endmodule

bind pport_regwin pport_regwin_chk #(.TMO_CYC(TMO_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .idx         (idx),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .pd_oe       (pd_oe),
  .epp_astb_n  (epp_astb_n),
  .epp_dstb_n  (epp_dstb_n),
  .epp_write_n (epp_write_n),
  .irq         (irq),
  .ctl_dir     (ctrl_q[5]),
  .ctl_ien     (ctrl_q[4]),
  .epp_busy    (epp_busy),
  .tmo_flag    (tmo_flag),
  .tmo_set     (tmo_set),
  .ack_fall    (ack_fall)
);

// File: tb/sim_pport_regwin.sv
`timescale 1ns/1ps
module sim_pport_regwin;
  localparam int STB = 2;
  localparam int TMO = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, pd_out;
  logic       pd_oe;
  logic [7:0] pd_in = '0;
  logic       lp_strobe, lp_autofeed, lp_init_n, lp_select_in;
  logic       pin_err_n = 1'b1, pin_select = 1'b1, pin_paper_end = 1'b0;
  logic       pin_ack_n = 1'b1, pin_busy_n = 1'b1, epp_wait = 1'b0;
  logic       epp_astb_n, epp_dstb_n, epp_write_n, irq;

  int  n_chk = 0, n_fail = 0;
  bit  fin = 0;

  always #2.5 clk = ~clk;

  pport_regwin u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_out(pd_out), .pd_oe(pd_oe),
    .pd_in(pd_in), .lp_strobe(lp_strobe), .lp_autofeed(lp_autofeed),
    .lp_init_n(lp_init_n), .lp_select_in(lp_select_in), .pin_err_n(pin_err_n),
    .pin_select(pin_select), .pin_paper_end(pin_paper_end), .pin_ack_n(pin_ack_n),
    .pin_busy_n(pin_busy_n), .epp_wait(epp_wait), .epp_astb_n(epp_astb_n),
    .epp_dstb_n(epp_dstb_n), .epp_write_n(epp_write_n), .irq(irq)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_data;
  logic [5:0]  m_ctrl;
  logic        m_tmo, m_irqf, m_ackd;
  logic [13:0] s1, s2;
  logic        m_busy, m_seen, m_isaddr, m_iswr;
  int          m_cyc;
  logic [7:0]  m_byte;

  function automatic logic [13:0] pins_now();
    return {epp_wait, pd_in, pin_busy_n, pin_ack_n, pin_paper_end, pin_select, pin_err_n};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 0; m_ctrl = 0; m_tmo = 0; m_irqf = 0; m_ackd = 0;
      s1 = 0; s2 = 0; m_busy = 0; m_seen = 0; m_isaddr = 0; m_iswr = 0;
      m_cyc = 0; m_byte = 0;
    end else begin
      int  off;
      bit  srd, fall, wt, tset, resp;
      off  = int'(bus_addr[4:2]);
      srd  = bus_rd && off == 1;
      fall = m_ackd && !s2[3];
      wt   = s2[13];
      tset = 0;
      if ((bus_wr || bus_rd) && off >= 3 && !m_busy) begin
        m_busy = 1; m_cyc = 0; m_seen = 0;
        m_isaddr = (off == 3); m_iswr = bus_wr; m_byte = bus_wdata;
      end else if (m_busy) begin
        resp = m_seen || wt;
        if (m_cyc >= STB - 1 && resp) m_busy = 0;
        else if (m_cyc == TMO - 1) begin m_busy = 0; tset = 1; end
        else begin m_cyc++; m_seen = resp; end
      end
      if (tset) m_tmo = 1; else if (srd) m_tmo = 0;
      if (fall && m_ctrl[4]) m_irqf = 1; else if (srd) m_irqf = 0;
      if (bus_wr && off == 0) m_data = bus_wdata;
      if (bus_wr && off == 2) m_ctrl = bus_wdata[5:0];
      m_ackd = s2[3];
      s2 = s1;
      s1 = pins_now();
    end
  end

  function automatic logic [7:0] exp_rd();
    case (int'(bus_addr[4:2]))
      0: return m_ctrl[5] ? s2[12:5] : m_data;
      1: return {s2[4], s2[3], s2[2], s2[1], s2[0], 2'b00, m_tmo};
      2: return {2'b00, m_ctrl};
      default: return s2[12:5];
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      bit ew;
      #1;
      ew = m_busy && m_iswr;
      check("R1", "rdata", bus_rdata, exp_rd());
      check("R2", "pd_oe", pd_oe, ew || !m_ctrl[5]);
      check("R2", "pd_out", pd_out, ew ? m_byte : m_data);
      check("R7", "astb_n", epp_astb_n, !(m_busy && m_isaddr && m_cyc < STB));
      check("R7", "dstb_n", epp_dstb_n, !(m_busy && !m_isaddr && m_cyc < STB));
      check("R7", "write_n", epp_write_n, !ew);
      check("R9", "irq", irq, m_irqf && m_ctrl[4]);
      check("R4", "lines", {lp_select_in, lp_init_n, lp_autofeed, lp_strobe}, m_ctrl[3:0]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus_write(logic [4:0] a, logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    idle(4);
    rst_n = 1'b1;
    idle(1); #1;
    // R11 reset state
    check("R11", "pd_oe", pd_oe, 1);
    check("R11", "pd_out", pd_out, 0);
    check("R11", "init_n", lp_init_n, 0);
    check("R11", "strobes", {epp_astb_n, epp_dstb_n, epp_write_n}, 3'b111);
    check("R11", "irq", irq, 0);

    // R2 data write and readback
    bus_write(5'h00, 8'hA5);
    bus_read(5'h00, v);
    check("R2", "data readback", v, 8'hA5);
    check("R2", "pd_out", pd_out, 8'hA5);

    // R1 low address bits ignored
    bus_write(5'h03, 8'h3C);
    bus_read(5'h00, v);
    check("R1", "aliased data", v, 8'h3C);

    // R4 control layout
    bus_write(5'h08, 8'hC7);
    bus_read(5'h0A, v);
    check("R4", "ctrl readback", v, 8'h07);
    #1;
    check("R4", "lines", {lp_select_in, lp_init_n, lp_autofeed, lp_strobe}, 4'b0111);

    // R3 input direction
    pd_in = 8'h5A;
    bus_write(5'h08, 8'h24);
    #1 check("R3", "pd_oe", pd_oe, 0);
    idle(3);
    bus_read(5'h00, v);
    check("R3", "pin read", v, 8'h5A);
    bus_write(5'h00, 8'h11);
    bus_read(5'h00, v);
    check("R3", "pins still", v, 8'h5A);
    bus_write(5'h08, 8'h04);
    bus_read(5'h00, v);
    check("R3", "stored byte kept", v, 8'h11);

    // R5 status layout
    pin_err_n = 0; pin_paper_end = 1; pin_busy_n = 0;
    idle(3);
    bus_read(5'h04, v);
    check("R5", "status", v, 8'h70);

    // R6 status write ignored
    bus_write(5'h04, 8'hFF);
    bus_read(5'h04, v);
    check("R6", "status after write", v, 8'h70);
    bus_read(5'h08, v);
    check("R6", "ctrl after write", v, 8'h04);
    bus_read(5'h00, v);
    check("R6", "data after write", v, 8'h11);

    // R7 enhanced data write, wait answers
    epp_wait = 1;
    idle(3);
    bus_write(5'h10, 8'h9C);
    #1;
    check("R7", "dstb low 1", epp_dstb_n, 0);
    check("R7", "write byte", pd_out, 8'h9C);
    check("R7", "write_n", epp_write_n, 0);
    check("R7", "astb idle", epp_astb_n, 1);
    @(negedge clk); #1;
    check("R7", "dstb low 2", epp_dstb_n, 0);
    @(negedge clk); #1;
    check("R7", "dstb released", epp_dstb_n, 1);
    check("R7", "write done", epp_write_n, 1);
    check("R7", "pd back to data", pd_out, 8'h11);

    // R8 / R10 enhanced address read with no wait response
    epp_wait = 0;
    idle(3);
    bus_read(5'h0C, v);
    check("R10", "epp read", v, 8'h5A);
    #1 check("R7", "astb low 1", epp_astb_n, 0);
    @(negedge clk); #1 check("R7", "astb low 2", epp_astb_n, 0);
    @(negedge clk); #1 check("R7", "astb released", epp_astb_n, 1);
    bus_write(5'h14, 8'h77);
    #1;
    check("R10", "busy ignore dstb", epp_dstb_n, 1);
    check("R10", "busy ignore write", epp_write_n, 1);
    idle(8);
    bus_read(5'h04, v);
    check("R8", "no timeout yet", v, 8'h70);
    idle(5);
    bus_read(5'h04, v);
    check("R8", "timeout set", v, 8'h71);
    bus_read(5'h04, v);
    check("R8", "timeout cleared", v, 8'h70);

    // R9 interrupt
    bus_write(5'h08, 8'h14);
    @(negedge clk); pin_ack_n = 0;
    idle(4); #1;
    check("R9", "irq set", irq, 1);
    pin_ack_n = 1;
    bus_read(5'h04, v);
    #1 check("R9", "irq cleared", irq, 0);
    idle(3);
    pin_ack_n = 0;
    idle(4); #1;
    check("R9", "irq set again", irq, 1);
    bus_write(5'h08, 8'h04);
    #1 check("R9", "irq gated", irq, 0);
    pin_ack_n = 1;
    bus_read(5'h04, v);
    idle(3);
    pin_ack_n = 0;
    idle(4);
    bus_write(5'h08, 8'h14);
    #1 check("R9", "edge lost while disabled", irq, 0);

    idle(4);
    finish_run();
  end
endmodule